// File: doc/BRIEF.md
# Eight-Line Interrupt Controller

This block gathers eight interrupt request lines and decides which one the processor should service next. When a request can be forwarded, it raises one interrupt output. The processor then answers with two acknowledge pulses. The first pulse locks in the winning line and marks that line as in service. The second pulse makes the block present a vector byte, which is formed from a programmed base and the number of the winning line.

Software sets the block up and controls it through a small register bus. The bus has one address bit and write-only strobes, and reads are combinational. Two initialization writes choose the following:
- the trigger style (edge or level);
- the vector spacing;
- the vector base.

After initialization, command writes do these jobs:
- mask individual lines;
- end service of a line, either the highest-priority one or a named one;
- switch rotating priority on or off;
- choose which status register a read returns.

Top module: `pic_ctrl`

## Requirements
- R1: After reset, `irq_o` and `vec_valid_o` are 0, and reads at both addresses return 0. `irq_o` stays 0 until both initialization writes have completed, whatever the request lines do.
- R2: A write at address 0 with data bit 4 set is the first initialization word. Bit 3 = 1 selects level triggering, and bit 2 = 1 selects 4-byte vector spacing. This write clears the mask, the in-service bits and rotation, selects request-register reads, and holds `irq_o` low. The next write at address 1 loads the vector base and completes initialization.
- R3: With rotation off, line 0 has the highest priority and line 7 the lowest. The highest-priority pending, unmasked line wins.
- R4: After initialization, a write at address 1 loads the mask register, in which bit i = 1 masks line i. A masked line cannot raise `irq_o`, but its request bit stays visible in the request register. Reads at address 1 return the mask.
- R5: A request is forwarded on `irq_o` only if its priority is strictly higher than that of every line marked in service.
- R6: In edge mode, the request bit is set by a rising edge on the line one clock after the edge. It stays set only while the line remains high, and it is cleared when that line wins a first acknowledge. In level mode, the request bit follows the line one clock later.
- R7: The first `ack_i` pulse freezes the winner and sets its in-service bit. `vec_valid_o` is 1 for exactly one cycle, namely the cycle after the second `ack_i` pulse.
- R8: The vector depends on the spacing bit. With 4-byte spacing it is {base[7:5], line[2:0], 2'b00}. With 8-byte spacing it is {base[7:6], line[2:0], 3'b000}.
- R9: If no request can be forwarded at the first acknowledge, the acknowledge sequence still completes. The vector then uses line 7, and no in-service bit is set.
- R10: Command 0x20 clears the highest-priority in-service bit. Command 0x60|n clears in-service bit n.
- R11: Command 0x80 enables rotation, and command 0x00 disables it and restores fixed order. While rotation is on, the line cleared by an end-of-service command becomes the lowest priority, and the line after it becomes the highest.
- R12: Reads at address 0 return the request register after command 0x0A and the in-service register after command 0x0B. In both registers, bit i corresponds to line i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 8 | Interrupt request lines, bit i = line i |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data for `addr_i` |
| ack_i | input | 1 | Acknowledge pulse from the processor |
| irq_o | output | 1 | Interrupt request to the processor |
| vec_valid_o | output | 1 | Vector byte valid |
| vec_o | output | 8 | Vector byte |

## Verification
The hardest case to reach is a first acknowledge that arrives after a request has gone away. The bench raises a line until `irq_o` rises, drops it for one clock so that the edge-latched bit clears, and then sends both acknowledges. It expects the line-7 vector and an empty in-service register.

Rotation is equally indirect. A line must first be serviced and ended, and only then can two lines pending together show that a lower-numbered line now loses. The bench checks this both through the winning vector and through `irq_o` staying low under nesting.

A behavioural model in the bench follows every cycle, so these cases are also checked against it.

// File: rtl/pic_pkg.sv
// Shared constants and types for the interrupt controller.
// Assumes exactly eight request lines; the vector format relies on 3-bit indices.
package pic_pkg;
    localparam int NUM_IN = 8;
    localparam int IDX_W  = $clog2(NUM_IN);
    localparam int POS_W  = IDX_W + 1;

    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [NUM_IN-1:0] lines_t;
    typedef logic [POS_W-1:0]  pos_t;

    typedef struct packed {
        logic       level;   // 1: level triggered, 0: edge triggered
        logic       int4;    // 1: 4-byte vector spacing, 0: 8-byte
        logic [2:0] base;    // vector base bits [7:5]
    } cfg_t;
endpackage

// File: rtl/pic_regs.sv
// Register-bus decoder: the two initialization words, the mask, the read
// select, the rotation flag and the end-of-service strobes.
// Assumes single-cycle write strobes; commands are ignored until init completes.
module pic_regs
    import pic_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   wr_en_i,
    input  logic   addr_i,
    input  logic [7:0] wdata_i,
    output cfg_t   cfg_o,
    output lines_t mask_o,
    output logic   init_done_o,
    output logic   rsel_isr_o,
    output logic   rot_en_o,
    output logic   init_pulse_o,
    output logic   rot_clr_o,
    output logic   eoi_ns_o,
    output logic   eoi_sp_o,
    output idx_t   eoi_idx_o
);
    logic pend_q;
    logic is_w1, is_w2, is_mask, is_ocw, is_rsel, is_cmd, rot_set, rot_off;

    // Decode the current write into one kind of access.
    always_comb begin
        is_w1   = wr_en_i && !addr_i && wdata_i[4];
        is_w2   = wr_en_i && addr_i && pend_q;
        is_mask = wr_en_i && addr_i && init_done_o;
        is_ocw  = wr_en_i && !addr_i && !wdata_i[4] && init_done_o;
        is_rsel = is_ocw && wdata_i[3];
        is_cmd  = is_ocw && !wdata_i[3];
        rot_set = is_cmd && (wdata_i[7:5] == 3'b100);
        rot_off = is_cmd && (wdata_i[7:5] == 3'b000);
    end

    assign eoi_ns_o     = is_cmd && (wdata_i[7:5] == 3'b001);
    assign eoi_sp_o     = is_cmd && (wdata_i[7:5] == 3'b011);
    assign eoi_idx_o    = wdata_i[IDX_W-1:0];
    assign init_pulse_o = is_w1;
    assign rot_clr_o    = rot_off || is_w1;

    // Hold configuration, mask and mode flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_o       <= '0;
            mask_o      <= '0;
            pend_q      <= 1'b0;
            init_done_o <= 1'b0;
            rsel_isr_o  <= 1'b0;
            rot_en_o    <= 1'b0;
        end else if (is_w1) begin
            cfg_o.level <= wdata_i[3];
            cfg_o.int4  <= wdata_i[2];
            mask_o      <= '0;
            pend_q      <= 1'b1;
            init_done_o <= 1'b0;
            rsel_isr_o  <= 1'b0;
            rot_en_o    <= 1'b0;
        end else if (is_w2) begin
            cfg_o.base  <= wdata_i[7:5];
            pend_q      <= 1'b0;
            init_done_o <= 1'b1;
        end else if (is_mask) begin
            mask_o <= wdata_i;
        end else begin
            if (is_rsel && wdata_i[1]) rsel_isr_o <= wdata_i[0];
            if (rot_set) rot_en_o <= 1'b1;
            if (rot_off) rot_en_o <= 1'b0;
        end
    end
endmodule

// File: rtl/pic_resolver.sv
// Combinational priority resolver. Scans from the line after the current
// lowest-priority line, finds the best pending unmasked request and the
// best in-service line, and forwards the request only if it outranks them.
// Assumes low_i names the current lowest-priority line (7 in fixed order).
module pic_resolver
    import pic_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  lines_t irr_i,
    input  lines_t mask_i,
    input  lines_t isr_i,
    input  idx_t   low_i,
    input  logic   en_i,
    output logic   fwd_o,
    output idx_t   win_idx_o,
    output logic   isr_any_o,
    output idx_t   isr_top_o
);
    lines_t elig;
    logic   req_hit;
    pos_t   req_pos, isr_pos;
    idx_t   p;

    // Walk priority positions from highest to lowest.
    always_comb begin
        elig      = irr_i & ~mask_i;
        req_hit   = 1'b0;
        isr_any_o = 1'b0;
        req_pos   = '0;
        isr_pos   = '0;
        win_idx_o = '0;
        isr_top_o = '0;
        p         = '0;
        for (int k = 0; k < NUM_IN; k++) begin
            p = idx_t'(low_i + idx_t'(k + 1));
            if (!req_hit && elig[p]) begin
                req_hit   = 1'b1;
                req_pos   = pos_t'(k);
                win_idx_o = p;
            end
            if (!isr_any_o && isr_i[p]) begin
                isr_any_o = 1'b1;
                isr_pos   = pos_t'(k);
                isr_top_o = p;
            end
        end
        fwd_o = en_i && req_hit && (!isr_any_o || (req_pos < isr_pos));
    end

    AST_WINNER_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_o |-> (!mask_i[win_idx_o] && irr_i[win_idx_o])); // R4
endmodule

// File: rtl/pic_service.sv
// Request, in-service and rotation state plus the two-pulse acknowledge
// sequencer and vector formatter.
// Assumes acknowledge and end-of-service commands do not fall in one cycle.
module pic_service
    import pic_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  lines_t req_i,
    input  cfg_t   cfg_i,
    input  logic   rot_en_i,
    input  logic   rot_clr_i,
    input  logic   init_pulse_i,
    input  logic   eoi_ns_i,
    input  logic   eoi_sp_i,
    input  idx_t   eoi_idx_i,
    input  logic   ack_i,
    input  logic   fwd_i,
    input  idx_t   win_idx_i,
    input  logic   isr_any_i,
    input  idx_t   isr_top_i,
    output lines_t irr_o,
    output lines_t isr_o,
    output idx_t   low_o,
    output logic   vec_valid_o,
    output logic [7:0] vec_o
);
    lines_t prev_q, set_v, clr_v, irr_n;
    logic   phase_q, ack1, ack2;
    idx_t   widx_q;

    function automatic logic [7:0] fmt_vec(input logic int4, input logic [2:0] base, input idx_t i);
        return int4 ? {base, i, 2'b00} : {base[2:1], i, 3'b000};
    endfunction

    // Derive set/clear masks and the next request register.
    always_comb begin
        ack1  = ack_i && !phase_q;
        ack2  = ack_i && phase_q;
        set_v = (ack1 && fwd_i) ? (lines_t'(1) << win_idx_i) : '0;
        if (eoi_ns_i && isr_any_i)  clr_v = lines_t'(1) << isr_top_i;
        else if (eoi_sp_i)          clr_v = lines_t'(1) << eoi_idx_i;
        else                        clr_v = '0;
        if (cfg_i.level) irr_n = req_i;
        else             irr_n = (irr_o | (req_i & ~prev_q)) & req_i & ~set_v;
    end

    // Update request, in-service and rotation state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            irr_o  <= '0;
            isr_o  <= '0;
            low_o  <= '1;
        end else begin
            prev_q <= req_i;
            irr_o  <= irr_n;
            isr_o  <= init_pulse_i ? '0 : ((isr_o | set_v) & ~clr_v);
            if (rot_clr_i)                           low_o <= '1;
            else if (rot_en_i && eoi_ns_i && isr_any_i) low_o <= isr_top_i;
            else if (rot_en_i && eoi_sp_i)           low_o <= eoi_idx_i;
        end
    end

    // Sequence the two acknowledge pulses and present the vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q     <= 1'b0;
            widx_q      <= '1;
            vec_valid_o <= 1'b0;
            vec_o       <= '0;
        end else begin
            vec_valid_o <= ack2;
            if (ack_i) phase_q <= !phase_q;
            if (ack1)  widx_q  <= fwd_i ? win_idx_i : '1;
            if (ack2)  vec_o   <= fmt_vec(cfg_i.int4, cfg_i.base, widx_q);
        end
    end

    AST_ONE_ISR_PER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ack1 |=> ($countones(isr_o & ~$past(isr_o)) <= 1)); // R7
    AST_SPURIOUS_NO_ISR: assert property (@(posedge clk) disable iff (!rst_n)
        (ack1 && !fwd_i) |=> ((isr_o & ~$past(isr_o)) == '0)); // R9
    AST_VEC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid_o |=> !vec_valid_o); // R7
    AST_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_sp_i && !ack_i) |=> !isr_o[$past(eoi_idx_i)]); // R10
endmodule

// File: rtl/pic_ctrl.sv
// Top level of the eight-line interrupt controller: register decoder,
// priority resolver and service state, plus the status read multiplexer.
// Assumes the processor issues acknowledge pulses in pairs.
module pic_ctrl
    import pic_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] req_i,
    input  logic       wr_en_i,
    input  logic       addr_i,
    input  logic [7:0] wdata_i,
    output logic [7:0] rdata_o,
    input  logic       ack_i,
    output logic       irq_o,
    output logic       vec_valid_o,
    output logic [7:0] vec_o
);
    cfg_t   cfg;
    lines_t mask, irr, isr;
    logic   init_done, rsel_isr, rot_en, init_pulse, rot_clr, eoi_ns, eoi_sp;
    logic   fwd, isr_any;
    idx_t   eoi_idx, win_idx, isr_top, low;

    pic_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .cfg_o(cfg), .mask_o(mask), .init_done_o(init_done),
        .rsel_isr_o(rsel_isr), .rot_en_o(rot_en), .init_pulse_o(init_pulse),
        .rot_clr_o(rot_clr), .eoi_ns_o(eoi_ns), .eoi_sp_o(eoi_sp),
        .eoi_idx_o(eoi_idx)
    );

    pic_resolver u_res (
        .clk(clk), .rst_n(rst_n), .irr_i(irr), .mask_i(mask), .isr_i(isr),
        .low_i(low), .en_i(init_done), .fwd_o(fwd), .win_idx_o(win_idx),
        .isr_any_o(isr_any), .isr_top_o(isr_top)
    );

    pic_service u_svc (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .cfg_i(cfg), .rot_en_i(rot_en),
        .rot_clr_i(rot_clr), .init_pulse_i(init_pulse), .eoi_ns_i(eoi_ns),
        .eoi_sp_i(eoi_sp), .eoi_idx_i(eoi_idx), .ack_i(ack_i), .fwd_i(fwd),
        .win_idx_i(win_idx), .isr_any_i(isr_any), .isr_top_i(isr_top),
        .irr_o(irr), .isr_o(isr), .low_o(low), .vec_valid_o(vec_valid_o),
        .vec_o(vec_o)
    );

    // Select status register for reads.
    always_comb begin
        if (addr_i)        rdata_o = mask;
        else if (rsel_isr) rdata_o = isr;
        else               rdata_o = irr;
    end

    assign irq_o = fwd;
endmodule

// File: tb/sim_pic_ctrl.sv
`timescale 1ns/1ps
module sim_pic_ctrl;
    logic       clk = 1'b0;
    logic       rst_n, wr_en, addr, ack;
    logic [7:0] req, wdata, rdata, vec;
    logic       irq, vv;
    int checks = 0, fails = 0;

    always #2 clk = ~clk;

    pic_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req), .wr_en_i(wr_en), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .ack_i(ack), .irq_o(irq),
        .vec_valid_o(vv), .vec_o(vec)
    );

    // Behavioural reference model state.
    logic [7:0] m_irr, m_isr, m_mask, m_prev, m_vec, setm, clrm;
    logic [2:0] m_base;
    int  m_low, m_widx, newlow, w, top;
    bit  m_level, m_int4, m_init, m_pend, m_rsel, m_rot, m_phase, m_vv, f;

    function automatic int rank(int i, int low);
        return (i - low - 1 + 16) % 8;
    endfunction

    function automatic int best(logic [7:0] v, int low);
        int b = -1;
        for (int i = 0; i < 8; i++)
            if (v[i] && (b < 0 || rank(i, low) < rank(b, low))) b = i;
        return b;
    endfunction

    function automatic bit fwd_now(bit init, logic [7:0] irr, logic [7:0] mask, logic [7:0] isr, int low);
        int r = best(irr & ~mask, low);
        int s = best(isr, low);
        if (!init || r < 0) return 1'b0;
        if (s < 0) return 1'b1;
        return rank(r, low) < rank(s, low);
    endfunction

    function automatic logic [7:0] fmt(bit int4, logic [2:0] base, int idx);
        return int4 ? {base, 3'(idx), 2'b00} : {base[2:1], 3'(idx), 3'b000};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_irr = 0; m_isr = 0; m_mask = 0; m_prev = 0; m_vec = 0; m_base = 0;
            m_low = 7; m_widx = 7; m_level = 0; m_int4 = 0; m_init = 0; m_pend = 0;
            m_rsel = 0; m_rot = 0; m_phase = 0; m_vv = 0;
        end else begin
            f = fwd_now(m_init, m_irr, m_mask, m_isr, m_low);
            w = best(m_irr & ~m_mask, m_low);
            setm = 0; clrm = 0; newlow = m_low;
            if (ack && !m_phase && f) setm[w] = 1'b1;
            top = best(m_isr, m_low);
            if (wr_en && !addr && !wdata[4] && !wdata[3] && m_init) begin
                if (wdata[7:5] == 3'd1 && top >= 0) begin clrm[top] = 1'b1; if (m_rot) newlow = top; end
                if (wdata[7:5] == 3'd3) begin clrm[wdata[2:0]] = 1'b1; if (m_rot) newlow = int'(wdata[2:0]); end
                if (wdata[7:5] == 3'd0) newlow = 7;
            end
            if (wr_en && !addr && wdata[4]) newlow = 7;
            m_isr = (wr_en && !addr && wdata[4]) ? 8'h00 : ((m_isr | setm) & ~clrm);
            m_vv = 0;
            if (ack) begin
                if (!m_phase) begin m_widx = f ? w : 7; m_phase = 1; end
                else begin m_vv = 1; m_vec = fmt(m_int4, m_base, m_widx); m_phase = 0; end
            end
            m_irr = m_level ? req : ((m_irr | (req & ~m_prev)) & req & ~setm);
            m_prev = req; m_low = newlow;
            if (wr_en) begin
                if (!addr && wdata[4]) begin
                    m_level = wdata[3]; m_int4 = wdata[2]; m_mask = 0; m_pend = 1;
                    m_init = 0; m_rsel = 0; m_rot = 0;
                end else if (addr && m_pend) begin
                    m_base = wdata[7:5]; m_pend = 0; m_init = 1;
                end else if (addr && m_init) begin
                    m_mask = wdata;
                end else if (!addr && m_init) begin
                    if (wdata[3]) begin if (wdata[1]) m_rsel = wdata[0]; end
                    else if (wdata[7:5] == 3'd4) m_rot = 1;
                    else if (wdata[7:5] == 3'd0) m_rot = 0;
                end
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Compare outputs with the model one nanosecond after every rising edge.
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            chk("R3 R5 irq vs model", int'(irq), int'(fwd_now(m_init, m_irr, m_mask, m_isr, m_low)));
            chk("R7 vec_valid vs model", int'(vv), int'(m_vv));
            if (m_vv) chk("R8 vec vs model", int'(vec), int'(m_vec));
            chk("R12 rdata vs model", int'(rdata), int'(addr ? m_mask : (m_rsel ? m_isr : m_irr)));
        end
    end

    task automatic tick();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic wr(bit a, logic [7:0] d);
        wr_en = 1; addr = a; wdata = d; tick(); wr_en = 0; addr = 0;
    endtask

    task automatic rd(bit a, string tag, int exp);
        addr = a; #0.5; chk(tag, int'(rdata), exp); addr = 0;
    endtask

    task automatic ack_pair();
        ack = 1; tick(); ack = 0; tick(); ack = 1; tick(); ack = 0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n = 0; req = 0; wr_en = 0; addr = 0; wdata = 0; ack = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk("R1 reset irq", int'(irq), 0);
        chk("R1 reset vec_valid", int'(vv), 0);
        rd(0, "R1 reset status", 0);
        rd(1, "R1 reset mask", 0);
        req = 8'h01; tick(); tick();
        chk("R1 no irq before init", int'(irq), 0);
        req = 8'h00; tick();
        wr(0, 8'h14);
        chk("R2 irq low between init words", int'(irq), 0);
        wr(1, 8'h40);
        req = 8'h28; tick();
        chk("R3 irq raised", int'(irq), 1);
        rd(0, "R6 edge latch irr", 8'h28);
        ack_pair();
        chk("R7 vec_valid after second ack", int'(vv), 1);
        chk("R8 R3 vector line 3 spacing 4", int'(vec), 8'h4C);
        tick();
        chk("R7 vec_valid one cycle", int'(vv), 0);
        wr(0, 8'h0B);
        rd(0, "R12 R7 isr after ack", 8'h08);
        chk("R5 lower line blocked", int'(irq), 0);
        req = 8'h2A; tick();
        chk("R5 higher line preempts", int'(irq), 1);
        ack_pair();
        chk("R3 vector line 1", int'(vec), 8'h44);
        rd(0, "R5 nested isr", 8'h0A);
        wr(0, 8'h20);
        rd(0, "R10 nonspecific clears top", 8'h08);
        wr(0, 8'h63);
        rd(0, "R10 specific clears line 3", 8'h00);
        chk("R5 line 5 forwarded", int'(irq), 1);
        wr(0, 8'h0A);
        rd(0, "R6 held lines not relatched", 8'h20);
        wr(1, 8'h20);
        chk("R4 masked no irq", int'(irq), 0);
        rd(0, "R4 request kept", 8'h20);
        rd(1, "R4 mask readback", 8'h20);
        wr(1, 8'h00);
        ack_pair();
        chk("R3 vector line 5", int'(vec), 8'h54);
        wr(0, 8'h20); req = 8'h00; tick();
        req = 8'h04; tick();
        chk("R9 irq before glitch", int'(irq), 1);
        req = 8'h00; tick();
        chk("R9 irq gone", int'(irq), 0);
        ack_pair();
        chk("R9 spurious vector", int'(vec), 8'h5C);
        wr(0, 8'h0B);
        rd(0, "R9 no isr on spurious", 8'h00);
        wr(0, 8'h80);
        req = 8'h01; tick();
        ack_pair();
        chk("R11 line 0 first", int'(vec), 8'h40);
        req = 8'h00; wr(0, 8'h20);
        req = 8'h11; tick();
        chk("R11 irq with rotation", int'(irq), 1);
        ack_pair();
        chk("R11 rotated winner line 4", int'(vec), 8'h50);
        chk("R11 line 0 now lowest", int'(irq), 0);
        wr(0, 8'h20);
        chk("R11 line 0 after eoi", int'(irq), 1);
        wr(0, 8'h00);
        ack_pair();
        chk("R11 fixed order restored", int'(vec), 8'h40);
        wr(0, 8'h20); req = 8'h00; tick();
        wr(1, 8'hFF);
        wr(0, 8'h18);
        rd(1, "R2 init clears mask", 0);
        wr(1, 8'hA0);
        req = 8'h40; tick();
        rd(0, "R6 R2 level irr", 8'h40);
        ack_pair();
        chk("R8 vector spacing 8", int'(vec), 8'hB0);
        rd(0, "R6 level bit held", 8'h40);
        req = 8'h00; tick();
        rd(0, "R6 level follows line", 8'h00);
        wr(0, 8'h0B);
        rd(0, "R12 isr level", 8'h40);
        wr(0, 8'h66);
        rd(0, "R10 specific line 6", 8'h00);
        tick();
        finish_run();
    end
endmodule